// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter with Byte-Wide Register Access

This block is a 16-bit up-counter for a peripheral bus with 8-bit data. It counts one of two sources. The internal source is a tick that fires once every four system clocks. The external source is the rising edges of a pin. The selected events pass through a prescaler that divides them by 1, 2, 4 or 8. In external mode the divided events can go through one extra alignment register (synchronous counting), or they can drive the counter directly (asynchronous counting). Edges on the pin are always sampled into the system clock domain first.

Software controls the block through four byte registers. It reads and writes the full 16-bit count without tearing, using a buffered high byte. Reading the low byte captures the live high byte into the buffer. Writing the low byte loads the buffer and the written byte into the counter together. A trigger input from a compare unit can zero the count when the control register permits it. A sticky overflow flag records each wrap from 0xFFFF to 0x0000.

Top module: `ctr16_periph`

## Requirements
- R1: With internal source and divide-by-1 selected, the count advances by exactly one per four system clocks. With divide-by-8 it advances by one per 32 clocks.
- R2: Control bits [4:3] set the prescale ratio: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R3: With control bit1 = 1 (external source), each rising edge of `extClkIn` is a source event. Falling edges and a held level are not events.
- R4: Control bit2 = 1 selects asynchronous counting: an input rise driven before clock edge 1 shows in the count after edge 3. With bit2 = 0 (synchronous) the same rise shows after edge 4.
- R5: While control bit0 (run) is 0, the count holds its value whatever the source does.
- R6: A one-cycle `specialEvt` pulse zeroes the whole count when control bit5 = 1. When bit5 = 0 the pulse has no effect.
- R7: A wrap from 0xFFFF to 0x0000 sets `ovfFlag`, which also reads as bit0 of address 3. The flag stays set, and writing 1 to bit0 leaves it set.
- R8: Writing 0 to bit0 of address 3 clears the flag. If a wrap happens in the same cycle as that write, the flag stays set.
- R9: Reading address 1 (low byte) copies the live high byte into the buffer at address 2. A later read of address 2 returns the high byte as it was at that earlier read.
- R10: Writing address 1 loads {buffer, written byte} into the counter in one cycle. Writing address 2 alone changes only the buffer and leaves the count unchanged.
- R11: Any write to address 1 also clears the prescaler, so counting restarts from a full prescale period.
- R12: After reset, the control register, count, buffer and flag all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 control, 1 count low, 2 high buffer, 3 status |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe, which causes the side effect on the high buffer |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| extClkIn | input | 1 | External count source pin |
| specialEvt | input | 1 | Clear trigger from the compare unit |
| ovfFlag | output | 1 | Sticky overflow interrupt flag |

## Verification
A wrong prescaler phase or a missed edge shows up as a count that is off by a fixed number after a known number of pulses. It is visible as soon as the low byte is read back. A sync stage that is off by one shifts the first visible increment by exactly one clock, so the bench looks at the count at edges 3 and 4 after an input rise. A buffer that latches at the wrong time returns a torn high byte right after the count carries across a byte boundary. A flag with the wrong priority shows on `ovfFlag` one cycle after a wrap that coincides with a clear.

// File: rtl/ctr16_pkg.sv
package ctr16_pkg;
  localparam int PRE_W = 3;

  // Control register layout; the first field declared is the MSB (bit5)
  typedef struct packed {
    logic       trigEn;
    logic [1:0] preSel;
    logic       asyncMode;
    logic       srcExt;
    logic       runEn;
  } cfg_t;

  typedef struct packed {
    logic loadCnt;
    logic clrCnt;
  } strobe_t;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LOW  = 2'd1,
    ADDR_HIGH = 2'd2,
    ADDR_STS  = 2'd3
  } addr_e;
endpackage

// File: rtl/ctr16_datapath.sv
module ctr16_datapath
  import ctr16_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             extClkIn,
  output logic [CNT_W-1:0] count,
  output logic             ovfPulse
);
  localparam int PH_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PH_W-1:0]  phase;
  logic             tickInt;
  logic [2:0]       extSh;
  logic             extRise;
  logic             srcEvt;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             preHit;
  logic             useAlign;
  logic             alignQ;
  logic             incEv;

  // Free-running internal tick: one pulse every TICK_DIV clocks
  assign tickInt = (phase == PH_W'(TICK_DIV - 1));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (tickInt) phase <= '0;
    else              phase <= phase + 1'b1;
  end

  // Two sampling flops, then one more flop for the edge compare
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) extSh <= '0;
    else        extSh <= {extSh[1:0], extClkIn};
  end
  assign extRise = extSh[1] & ~extSh[2];

  assign srcEvt = cfg.runEn & (cfg.srcExt ? extRise : tickInt);

  always_comb preMask = PRE_W'((4'd1 << cfg.preSel) - 4'd1);
  assign preHit = srcEvt && ((preCnt & preMask) == preMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           preCnt <= '0;
    else if (stb.loadCnt) preCnt <= '0;
    else if (srcEvt)      preCnt <= preHit ? '0 : preCnt + 1'b1;
  end

  // Synchronous external mode goes through one extra alignment register
  assign useAlign = cfg.srcExt & ~cfg.asyncMode;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           alignQ <= 1'b0;
    else if (stb.loadCnt) alignQ <= 1'b0;
    else                  alignQ <= preHit & useAlign;
  end

  assign incEv = cfg.runEn & ((preHit & ~useAlign) | alignQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (stb.loadCnt) count <= loadVal;
    else if (stb.clrCnt)  count <= '0;
    else if (incEv)       count <= count + 1'b1;
  end

  assign ovfPulse = incEv & ~stb.loadCnt & ~stb.clrCnt & (&count);

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.runEn && !stb.loadCnt && !stb.clrCnt) |=> (count == $past(count)));
  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.clrCnt && !stb.loadCnt) |=> (count == '0));
  a_r10_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    stb.loadCnt |=> (count == $past(loadVal)));
  a_r11_prescaler_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    stb.loadCnt |=> (preCnt == '0));
endmodule

// File: rtl/ctr16_ctrl.sv
module ctr16_ctrl
  import ctr16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [BYTE_W-1:0]   regWdata,
  output logic [BYTE_W-1:0]   regRdata,
  input  logic                specialEvt,
  input  logic [2*BYTE_W-1:0] count,
  input  logic                ovfPulse,
  output cfg_t                cfg,
  output strobe_t             stb,
  output logic [2*BYTE_W-1:0] loadVal,
  output logic                ovfFlag
);
  localparam int CFG_W = $bits(cfg_t);

  logic              wrCtrl, wrLow, wrHigh, wrSts, rdLow, swClr;
  logic [BYTE_W-1:0] hiBuf;

  assign wrCtrl = regWr && (regAddr == ADDR_CTRL);
  assign wrLow  = regWr && (regAddr == ADDR_LOW);
  assign wrHigh = regWr && (regAddr == ADDR_HIGH);
  assign wrSts  = regWr && (regAddr == ADDR_STS);
  assign rdLow  = regRd && (regAddr == ADDR_LOW);
  assign swClr  = wrSts && !regWdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (wrCtrl) cfg <= cfg_t'(regWdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hiBuf <= '0;
    else if (wrHigh) hiBuf <= regWdata;
    else if (rdLow)  hiBuf <= count[2*BYTE_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovfFlag <= 1'b0;
    else if (ovfPulse) ovfFlag <= 1'b1;
    else if (swClr)    ovfFlag <= 1'b0;
  end

  assign stb.loadCnt = wrLow;
  assign stb.clrCnt  = specialEvt & cfg.trigEn;
  assign loadVal     = {hiBuf, regWdata};

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdata = BYTE_W'(cfg);
      ADDR_LOW:  regRdata = count[BYTE_W-1:0];
      ADDR_HIGH: regRdata = hiBuf;
      default:   regRdata = BYTE_W'(ovfFlag);
    endcase
  end

  a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovfPulse |=> ovfFlag);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !swClr) |=> ovfFlag);
  a_r8_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (swClr && !ovfPulse) |=> !ovfFlag);
  a_r9_buffer_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (rdLow && !wrHigh) |=> (hiBuf == $past(count[2*BYTE_W-1:BYTE_W])));
endmodule

// File: rtl/ctr16_periph.sv
module ctr16_periph
  import ctr16_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              extClkIn,
  input  logic              specialEvt,
  output logic              ovfFlag
);
  localparam int CNT_W = 2 * BYTE_W;

  cfg_t             cfg;
  strobe_t          stb;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] count;
  logic             ovfPulse;

  ctr16_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .specialEvt(specialEvt),
    .count(count), .ovfPulse(ovfPulse), .cfg(cfg), .stb(stb),
    .loadVal(loadVal), .ovfFlag(ovfFlag)
  );

  ctr16_datapath #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_dp (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .stb(stb), .loadVal(loadVal),
    .extClkIn(extClkIn), .count(count), .ovfPulse(ovfPulse)
  );
endmodule

// File: tb/ctr16_periph_tb.sv
module ctr16_periph_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       extClkIn = 1'b0;
  logic       specialEvt = 1'b0;
  logic       ovfFlag;
  int checks = 0;
  int failures = 0;
  logic [7:0] rv, ra, rb;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr16_periph u_dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .extClkIn(extClkIn),
    .specialEvt(specialEvt), .ovfFlag(ovfFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(posedge clk); @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(posedge clk); @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic setCount(input logic [15:0] v);
    wrReg(2'd2, v[15:8]);
    wrReg(2'd1, v[7:0]);
  endtask

  task automatic extPulses(input int n);
    for (int i = 0; i < n; i++) begin
      extClkIn = 1'b1; repeat (3) @(negedge clk);
      extClkIn = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rdReg(2'd0, rv); check("R12 ctrl", rv, 0);
    rdReg(2'd1, rv); check("R12 low", rv, 0);
    rdReg(2'd2, rv); check("R12 high", rv, 0);
    rdReg(2'd3, rv); check("R12 status", rv, 0);
    check("R12 ovfFlag", ovfFlag, 0);
  endtask

  task automatic t_load();
    wrReg(2'd0, 8'h00);
    setCount(16'h1234);
    rdReg(2'd1, rv); check("R10 low after load", rv, 8'h34);
    rdReg(2'd2, rv); check("R9 high via buffer", rv, 8'h12);
    wrReg(2'd2, 8'hAB);
    rdReg(2'd1, rv); check("R10 buffer write keeps low", rv, 8'h34);
    rdReg(2'd2, rv); check("R10 buffer write keeps high", rv, 8'h12);
  endtask

  task automatic t_hold();
    wrReg(2'd0, 8'h06);
    setCount(16'h0005);
    extPulses(3);
    repeat (20) @(negedge clk);
    rdReg(2'd1, rv); check("R5 held while off", rv, 5);
  endtask

  task automatic t_ext();
    wrReg(2'd0, 8'h07);
    setCount(16'h0000);
    extPulses(5);
    rdReg(2'd1, rv); check("R3 five edges", rv, 5);
    extClkIn = 1'b1; repeat (10) @(negedge clk);
    rdReg(2'd1, rv); check("R3 held high counts once", rv, 6);
    extClkIn = 1'b0; repeat (10) @(negedge clk);
    rdReg(2'd1, rv); check("R3 falling edge ignored", rv, 6);
  endtask

  task automatic t_prescale();
    wrReg(2'd0, 8'h17); setCount(16'h0000); extPulses(8);
    rdReg(2'd1, rv); check("R2 ratio 4", rv, 2);
    wrReg(2'd0, 8'h1F); setCount(16'h0000); extPulses(8);
    rdReg(2'd1, rv); check("R2 ratio 8", rv, 1);
    wrReg(2'd0, 8'h0F); setCount(16'h0000); extPulses(8);
    rdReg(2'd1, rv); check("R2 ratio 2", rv, 4);
  endtask

  task automatic t_preclr();
    wrReg(2'd0, 8'h17); setCount(16'h0000); extPulses(3);
    setCount(16'h0000); extPulses(3);
    rdReg(2'd1, rv); check("R11 prescaler restarted", rv, 0);
    extPulses(1);
    rdReg(2'd1, rv); check("R11 full period reached", rv, 1);
  endtask

  task automatic latency(input logic [7:0] ctrl, input int edgeN, input string req);
    wrReg(2'd0, ctrl); setCount(16'h0000);
    repeat (4) @(negedge clk);
    regAddr = 2'd1;
    extClkIn = 1'b1;
    repeat (edgeN - 1) @(posedge clk);
    @(negedge clk); #1 check(req, regRdata, 0);
    @(posedge clk); @(negedge clk); #1 check(req, regRdata, 1);
    extClkIn = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic t_sync();
    latency(8'h07, 3, "R4 async at edge 3");
    latency(8'h03, 4, "R4 sync at edge 4");
  endtask

  task automatic t_internal();
    wrReg(2'd0, 8'h01); setCount(16'h0000);
    rdReg(2'd1, ra);
    repeat (39) @(posedge clk); @(negedge clk);
    rdReg(2'd1, rb); check("R1 ratio 1 window", 8'(rb - ra), 10);
    wrReg(2'd0, 8'h19); setCount(16'h0000);
    rdReg(2'd1, ra);
    repeat (63) @(posedge clk); @(negedge clk);
    rdReg(2'd1, rb); check("R1 ratio 8 window", 8'(rb - ra), 2);
  endtask

  task automatic t_trig();
    wrReg(2'd0, 8'h20); setCount(16'h0F0F);
    specialEvt = 1'b1; @(posedge clk); @(negedge clk); specialEvt = 1'b0;
    rdReg(2'd1, rv); check("R6 cleared low", rv, 0);
    rdReg(2'd2, rv); check("R6 cleared high", rv, 0);
    wrReg(2'd0, 8'h00); setCount(16'h0F0F);
    specialEvt = 1'b1; @(posedge clk); @(negedge clk); specialEvt = 1'b0;
    rdReg(2'd1, rv); check("R6 trigger ignored when off", rv, 8'h0F);
  endtask

  task automatic t_ovf();
    wrReg(2'd0, 8'h07); setCount(16'hFFFF);
    check("R7 flag clear before wrap", ovfFlag, 0);
    extPulses(1);
    rdReg(2'd1, rv); check("R7 wrapped low", rv, 0);
    check("R7 flag set", ovfFlag, 1);
    rdReg(2'd3, rv); check("R7 status bit", rv, 1);
    wrReg(2'd3, 8'h01); check("R7 write 1 keeps flag", ovfFlag, 1);
    wrReg(2'd3, 8'h00); check("R8 write 0 clears", ovfFlag, 0);
    setCount(16'hFFFF);
    repeat (4) @(negedge clk);
    extClkIn = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    regAddr = 2'd3; regWdata = 8'h00; regWr = 1'b1;
    @(posedge clk); @(negedge clk);
    regWr = 1'b0;
    check("R8 set wins over clear", ovfFlag, 1);
    extClkIn = 1'b0; repeat (6) @(negedge clk);
    wrReg(2'd3, 8'h00);
  endtask

  task automatic t_atomic();
    wrReg(2'd0, 8'h07); setCount(16'h00FF);
    rdReg(2'd1, rv); check("R9 low before carry", rv, 8'hFF);
    extPulses(1);
    rdReg(2'd2, rv); check("R9 buffer coherent", rv, 8'h00);
    rdReg(2'd1, rv); check("R9 low after carry", rv, 8'h00);
    rdReg(2'd2, rv); check("R9 new high latched", rv, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_hold();
    t_ext();
    t_prescale();
    t_preclr();
    t_sync();
    t_internal();
    t_trig();
    t_ovf();
    t_atomic();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule